// File: doc/BRIEF.md
# Counting semaphore storage cell

This block is one counting-semaphore cell of an inter-thread communication unit. Threads reach it with single-cycle accesses that carry a view code, a read or write strobe and a requester number. Through the semaphore views a read takes the semaphore and a write gives it back. A take returns the count as it was before the take and lowers it by one if it was above zero. A give ignores its data and raises the count, which stops at its maximum.

A take in the blocking view that finds the count at zero is refused. The cell raises a one-cycle stall and notes the requester in a mask of waiting requesters. The next give that finds anyone in that mask sends a one-cycle wake pulse together with the whole mask, then empties the mask. The scheduler retries the woken threads. The other views behave as follows. Bypass reads the raw count. The queue-only views are inert. The control view exposes a small tag word.

All results are registered. Read data, stall, wake and the wake mask appear in the cycle after the strobe.

Top module: `sem_cell`

## Requirements
- R1: After reset the count is 0, the waiting mask is empty, the tag bits are 0, and stall, wake and wake_mask are 0.
- R2: A read in view 4 (blocking take) or view 5 (non-blocking take) returns the count from before the access on rd_data one cycle later. If that count was above zero, the count drops by one.
- R3: A view 4 read of a zero count returns 0 and pulses stall for one cycle. It sets bit req_id of the waiting mask and leaves the count at 0.
- R4: A view 5 read of a zero count returns 0 without stall and leaves the waiting mask unchanged.
- R5: A write in view 4 or 5 ignores wr_data and raises the count by one. The count saturates at 2^CNT_W-1.
- R6: A view 4 or 5 write that finds a non-empty waiting mask pulses wake for one cycle with wake_mask equal to that mask, and clears the mask. A write that finds the mask empty leaves wake and wake_mask at 0.
- R7: A view 0 (bypass) read returns the count and does not change it. A view 0 write has no effect.
- R8: Reads in views 2 and 3 (queue views) return 0, and writes in those views have no effect.
- R9: A view 1 (control) read returns the tag word: E at bit 0, F at bit 1, T at bit 16, and the queue-type flag at bit 17 reading 0. All other bits are 0. A view 1 write loads only those three bits from the same positions and leaves the count alone.
- R10: When rd_en and wr_en are high in the same cycle, only the read is performed.
- R11: Reads in views 6 and 7 return all ones, and writes in those views have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| view | input | 3 | Access view code |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| req_id | input | ID_W | Requesting thread number |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read result, valid the cycle after rd_en |
| stall | output | 1 | One-cycle pulse: the blocking take was refused |
| wake | output | 1 | One-cycle pulse: waiting requesters released |
| wake_mask | output | REQ_W | Requesters released with wake |

## Verification
The bench builds the cell with CNT_W=4 and REQ_W=4. With those values, saturation at 15 takes only a handful of gives. Every requester bit in the waiting mask can be set and checked through wake_mask. DATA_W stays at 32, so the tag word and the all-ones reserved read are seen at full width.

// File: rtl/sem_cell.sv
module sem_cell #(
  parameter int CNT_W  = 16,
  parameter int REQ_W  = 16,
  parameter int DATA_W = 32,
  localparam int ID_W  = (REQ_W > 1) ? $clog2(REQ_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        view,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ID_W-1:0]   req_id,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              stall,
  output logic              wake,
  output logic [REQ_W-1:0]  wake_mask
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [REQ_W-1:0] blk;
  logic             tag_e, tag_f, tag_t;
  logic [DATA_W-1:0] rd_val;

  wire is_pv = (view == 3'd4) || (view == 3'd5);
  wire pv_sync = (view == 3'd4);
  wire rd = rd_en;
  wire wr = wr_en & ~rd_en;
  wire cnt_zero = (cnt == '0);

  always_comb begin
    rd_val = '0;
    case (view)
      3'd0, 3'd4, 3'd5: rd_val[CNT_W-1:0] = cnt;
      3'd1: begin
        rd_val[0]  = tag_e;
        rd_val[1]  = tag_f;
        rd_val[16] = tag_t;
      end
      3'd2, 3'd3: rd_val = '0;
      default: rd_val = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      blk       <= '0;
      tag_e     <= 1'b0;
      tag_f     <= 1'b0;
      tag_t     <= 1'b0;
      rd_data   <= '0;
      stall     <= 1'b0;
      wake      <= 1'b0;
      wake_mask <= '0;
    end else begin
      stall     <= 1'b0;
      wake      <= 1'b0;
      wake_mask <= '0;
      if (rd) begin
        rd_data <= rd_val;
        if (is_pv) begin
          if (!cnt_zero) cnt <= cnt - 1'b1;
          else if (pv_sync) begin
            stall       <= 1'b1;
            blk[req_id] <= 1'b1;
          end
        end
      end else if (wr) begin
        if (view == 3'd1) begin
          tag_e <= wr_data[0];
          tag_f <= wr_data[1];
          tag_t <= wr_data[16];
        end else if (is_pv) begin
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          if (blk != '0) begin
            wake      <= 1'b1;
            wake_mask <= blk;
            blk       <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sem_cell_chk.sv
module sem_cell_chk #(
  parameter int CNT_W = 16,
  parameter int REQ_W = 16,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       view,
  input logic             rd_en,
  input logic             wr_en,
  input logic [ID_W-1:0]  req_id,
  input logic [CNT_W-1:0] cnt,
  input logic [REQ_W-1:0] blk,
  input logic             stall,
  input logic             wake
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_take_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (view == 3'd4 || view == 3'd5) && cnt != '0 |=> cnt == CNT_W'($past(cnt) - 1'b1));

  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && view == 3'd4 && cnt == '0 |=> stall && blk[$past(req_id)] && cnt == '0);

  p_try_nostall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && view == 3'd5 |=> !stall && $stable(blk));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && (view == 3'd4 || view == 3'd5) && cnt == CMAX |=> cnt == CMAX);

  p_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && (view == 3'd4 || view == 3'd5) && blk != '0 |=> wake && blk == '0);

  p_wake_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(wr_en) && !$past(rd_en));

  p_bypass_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && view == 3'd0 |=> $stable(cnt) && $stable(blk));
endmodule

bind sem_cell sem_cell_chk #(.CNT_W(CNT_W), .REQ_W(REQ_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .view(view), .rd_en(rd_en), .wr_en(wr_en),
  .req_id(req_id), .cnt(cnt), .blk(blk), .stall(stall), .wake(wake)
);

// File: tb/test_sem_cell.sv
module test_sem_cell;
  localparam int CW = 4, RW = 4, DW = 32, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [2:0] view = '0;
  logic rd_en = 0, wr_en = 0;
  logic [IW-1:0] req_id = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic stall, wake;
  logic [RW-1:0] wake_mask;
  int checks = 0, errors = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  sem_cell #(.CNT_W(CW), .REQ_W(RW), .DATA_W(DW)) i_sem_cell (
    .clk(clk), .rst_n(rst_n), .view(view), .rd_en(rd_en), .wr_en(wr_en),
    .req_id(req_id), .wr_data(wr_data), .rd_data(rd_data),
    .stall(stall), .wake(wake), .wake_mask(wake_mask));

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(logic [2:0] v, logic r, logic w, logic [IW-1:0] id, logic [DW-1:0] d);
    view = v; rd_en = r; wr_en = w; req_id = id; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    rd_en = 0; wr_en = 0;
  endtask

  task automatic check_cnt(string req);
    op(3'd0, 1, 0, '0, '0);
    check(req, rd_data, DW'(exp_cnt));
  endtask

  task automatic t_reset;
    check("R1 stall", DW'(stall), 0);
    check("R1 wake", DW'(wake), 0);
    check("R1 wake_mask", DW'(wake_mask), 0);
    op(3'd1, 1, 0, '0, '0);
    check("R1 tag", rd_data, 0);
    check_cnt("R1 count");
  endtask

  task automatic t_try_zero;
    op(3'd5, 1, 0, 2'd3, '0);
    check("R4 data", rd_data, 0);
    check("R4 stall", DW'(stall), 0);
    check_cnt("R4 count");
  endtask

  task automatic t_give;
    for (int i = 0; i < 3; i++) begin
      op(3'd4 + 3'(i % 2), 0, 1, '0, 32'hDEAD_0000 + i);
      exp_cnt++;
      check("R6 no wake", DW'(wake), 0);
    end
    check_cnt("R5 give");
  endtask

  task automatic t_take;
    op(3'd5, 1, 0, 2'd1, '0);
    check("R2 try take", rd_data, DW'(exp_cnt));
    exp_cnt--;
    op(3'd4, 1, 0, 2'd1, '0);
    check("R2 sync take", rd_data, DW'(exp_cnt));
    check("R2 no stall", DW'(stall), 0);
    exp_cnt--;
    check_cnt("R2 count");
  endtask

  task automatic t_block_wake;
    while (exp_cnt > 0) begin op(3'd5, 1, 0, '0, '0); exp_cnt--; end
    op(3'd4, 1, 0, 2'd2, '0);
    check("R3 data", rd_data, 0);
    check("R3 stall", DW'(stall), 1);
    op(3'd4, 1, 0, 2'd0, '0);
    check("R3 stall2", DW'(stall), 1);
    op(3'd5, 1, 0, 2'd3, '0);
    check("R4 no mask", DW'(stall), 0);
    check_cnt("R3 count");
    op(3'd4, 0, 1, '0, '1);
    exp_cnt++;
    check("R6 wake", DW'(wake), 1);
    check("R6 mask", DW'(wake_mask), 32'h5);
    op(3'd5, 0, 1, '0, '0);
    exp_cnt++;
    check("R6 cleared", DW'(wake), 0);
    check("R6 mask0", DW'(wake_mask), 0);
    check_cnt("R5 after wake");
  endtask

  task automatic t_bypass_ef;
    op(3'd0, 0, 1, '0, 32'h9);
    check_cnt("R7 bypass write");
    op(3'd2, 1, 0, '0, '0);
    check("R8 ef read", rd_data, 0);
    op(3'd3, 1, 0, '0, '0);
    check("R8 ef try read", rd_data, 0);
    op(3'd2, 0, 1, '0, 32'h1);
    op(3'd3, 0, 1, '0, 32'h1);
    check_cnt("R8 ef write");
  endtask

  task automatic t_ctrl_rsvd;
    op(3'd1, 0, 1, '0, '1);
    op(3'd1, 1, 0, '0, '0);
    check("R9 tag", rd_data, 32'h0001_0003);
    op(3'd1, 0, 1, '0, 32'h0001_0000);
    op(3'd1, 1, 0, '0, '0);
    check("R9 tag T", rd_data, 32'h0001_0000);
    check_cnt("R9 count");
    op(3'd6, 1, 0, '0, '0);
    check("R11 read", rd_data, '1);
    op(3'd7, 0, 1, '0, '1);
    check_cnt("R11 write");
  endtask

  task automatic t_both;
    op(3'd5, 1, 1, '0, '0);
    check("R10 data", rd_data, DW'(exp_cnt));
    exp_cnt--;
    check_cnt("R10 count");
  endtask

  task automatic t_sat;
    while (exp_cnt < 15) begin op(3'd4, 0, 1, '0, '0); exp_cnt++; end
    op(3'd4, 0, 1, '0, '0);
    op(3'd5, 0, 1, '0, '0);
    check_cnt("R5 saturate");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_try_zero();
    t_give();
    t_take();
    t_block_wake();
    t_bypass_ef();
    t_ctrl_rsvd();
    t_both();
    t_sat();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule